// File: doc/BRIEF.md
# Queue Interrupt Controller

This block gathers completion events and error events from a set of endpoint data queues and turns them into one interrupt line. Completion events are latched into a single 32-bit status word. Transmit endpoints fill its low half and receive endpoints fill its high half. Error events are latched per endpoint into three error words. The first holds receive checksum and receive length errors. The second holds receive zero-length errors. The third holds transmit checksum and transmit length errors.

Every latched word has a companion enable word. The enabled bits of each error group are reduced to one summary bit, and a summary register gives software a quick view of which group needs service. Software clears status by writing ones to it. Endpoint 0 has no queue, so its bit positions are never implemented.

Top module: `queue_irq_ctrl`

## Requirements
- R1: After reset every status, enable and summary register reads 0 and `irq_o` is low.
- R2: A pulse on `tx_done_i[n]` sets bit n of the completion word at word address 0. A pulse on `rx_done_i[n]` sets bit 16+n of that word.
- R3: Inputs for endpoint 0 have no effect. Bit positions 0 and 16 of every status and enable word always read 0.
- R4: A write of ones to a status word clears exactly those bits. Bits written with zero keep their value.
- R5: An event that arrives in the same cycle as a write that clears its bit leaves that bit set.
- R6: Error words have the following layout:
  - Word address 4 holds receive checksum errors in bits 15:0 and receive length errors in bits 31:16.
  - Word address 6 holds receive zero-length errors in bits 15:0.
  - Word address 8 holds transmit checksum errors in bits 15:0 and transmit length errors in bits 31:16.
- R7: The summary word at address 2 is read-only, and writes to it are ignored. Each summary bit is the OR of its group's status bits ANDed with that group's per-endpoint enable. The bit positions are:
  - bit 0: receive checksum
  - bit 1: receive length
  - bit 2: receive zero-length
  - bit 3: transmit checksum
  - bit 4: transmit length
- R8: The enable words read back what was written, with unimplemented bits reading 0. The enable words are at these addresses:
  - address 1: completion enable
  - address 3: summary enable (bits 4:0)
  - address 5: enable for the word at address 4
  - address 7: enable for the word at address 6
  - address 9: enable for the word at address 8
- R9: `irq_o` goes high one cycle after any enabled completion bit or enabled summary bit becomes pending. It goes low one cycle after none remains.
- R10: Events whose enable is 0 are still recorded in status, but they do not raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_done_i | input | NUM_EP | Transmit queue completion pulses, one per endpoint |
| rx_done_i | input | NUM_EP | Receive queue completion pulses |
| rx_cs_err_i | input | NUM_EP | Receive checksum error pulses |
| rx_len_err_i | input | NUM_EP | Receive length error pulses |
| rx_zlp_err_i | input | NUM_EP | Receive zero-length error pulses |
| tx_cs_err_i | input | NUM_EP | Transmit checksum error pulses |
| tx_len_err_i | input | NUM_EP | Transmit length error pulses |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is a clear write and a new event that hit the same status bit on the same clock edge. The stimulus table lines up an event pulse and a write of one to the same bit in one cycle, and it also mixes clears of some bits with new events on others. A second hard case is the two-level path, where an error raises the interrupt only when both its per-endpoint enable and its group enable are set. Directed steps raise errors with only one of the two levels enabled, then enable the other level, and check the summary word and `irq_o` at each step.

// File: rtl/qic_pkg.sv
package qic_pkg;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned NUM_GRP = 5;

  // word addresses
  localparam logic [3:0] A_DONE = 4'd0;
  localparam logic [3:0] A_DONE_EN = 4'd1;
  localparam logic [3:0] A_SUM = 4'd2;
  localparam logic [3:0] A_SUM_EN = 4'd3;
  localparam logic [3:0] A_RXE = 4'd4;
  localparam logic [3:0] A_RXE_EN = 4'd5;
  localparam logic [3:0] A_ZLP = 4'd6;
  localparam logic [3:0] A_ZLP_EN = 4'd7;
  localparam logic [3:0] A_TXE = 4'd8;
  localparam logic [3:0] A_TXE_EN = 4'd9;

  typedef enum logic [2:0] {
    GRP_RX_CS = 3'd0,
    GRP_RX_LEN = 3'd1,
    GRP_RX_ZLP = 3'd2,
    GRP_TX_CS = 3'd3,
    GRP_TX_LEN = 3'd4
  } grp_e;

  // implemented endpoint bits: 1 .. n-1
  function automatic logic [HALF_W-1:0] ep_mask(input int unsigned n);
    logic [HALF_W-1:0] m;
    m = '0;
    for (int unsigned i = 1; i < HALF_W; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/qic_w1c_reg.sv
module qic_w1c_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] clr;

  assign clr = clr_we_i ? clr_data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else stat_q <= ((stat_q & ~clr) | set_i) & IMPL;
  end

  assign stat_o = stat_q;

  // R5
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & IMPL)) |=> ((stat_q & $past(set_i & IMPL)) == $past(set_i & IMPL)));

  // R4
  clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && (|(clr_data_i & ~set_i))) |=> ((stat_q & $past(clr_data_i & ~set_i)) == '0));
endmodule

// File: rtl/qic_rw_reg.sv
module qic_rw_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else if (we_i) q <= wdata_i & IMPL;
  end

  assign q_o = q;

  // R8
  write_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(wdata_i & IMPL)));
endmodule

// File: rtl/queue_irq_ctrl.sv
module queue_irq_ctrl
  import qic_pkg::*;
#(
  parameter int unsigned NUM_EP = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EP-1:0] tx_done_i,
  input  logic [NUM_EP-1:0] rx_done_i,
  input  logic [NUM_EP-1:0] rx_cs_err_i,
  input  logic [NUM_EP-1:0] rx_len_err_i,
  input  logic [NUM_EP-1:0] rx_zlp_err_i,
  input  logic [NUM_EP-1:0] tx_cs_err_i,
  input  logic [NUM_EP-1:0] tx_len_err_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  localparam logic [HALF_W-1:0] EPM = ep_mask(NUM_EP);
  localparam logic [31:0] PAIRM = {EPM, EPM};
  localparam logic [NUM_GRP-1:0] SUMM = '1;

  logic [HALF_W-1:0] tx_d, rx_d, rcs, rlen, rzlp, tcs, tlen;
  always_comb begin
    tx_d = '0; rx_d = '0; rcs = '0; rlen = '0; rzlp = '0; tcs = '0; tlen = '0;
    tx_d[NUM_EP-1:0] = tx_done_i;
    rx_d[NUM_EP-1:0] = rx_done_i;
    rcs[NUM_EP-1:0] = rx_cs_err_i;
    rlen[NUM_EP-1:0] = rx_len_err_i;
    rzlp[NUM_EP-1:0] = rx_zlp_err_i;
    tcs[NUM_EP-1:0] = tx_cs_err_i;
    tlen[NUM_EP-1:0] = tx_len_err_i;
  end

  logic [ADDR_W-1:0] a;
  assign a = reg_addr_i;
  function automatic logic hit(input logic [ADDR_W-1:0] x, input logic [3:0] y);
    return x == ADDR_W'(y);
  endfunction

  logic [31:0] done_q, done_en, rxe_q, rxe_en, txe_q, txe_en;
  logic [HALF_W-1:0] zlp_q, zlp_en;
  logic [NUM_GRP-1:0] sum, sum_en;

  qic_w1c_reg #(.W(32), .IMPL(PAIRM)) u_done (
    .clk_i, .rst_ni, .set_i({rx_d, tx_d}),
    .clr_we_i(reg_wr_i && hit(a, A_DONE)), .clr_data_i(reg_wdata_i), .stat_o(done_q));
  qic_w1c_reg #(.W(32), .IMPL(PAIRM)) u_rxe (
    .clk_i, .rst_ni, .set_i({rlen, rcs}),
    .clr_we_i(reg_wr_i && hit(a, A_RXE)), .clr_data_i(reg_wdata_i), .stat_o(rxe_q));
  qic_w1c_reg #(.W(HALF_W), .IMPL(EPM)) u_zlp (
    .clk_i, .rst_ni, .set_i(rzlp),
    .clr_we_i(reg_wr_i && hit(a, A_ZLP)), .clr_data_i(reg_wdata_i[HALF_W-1:0]), .stat_o(zlp_q));
  qic_w1c_reg #(.W(32), .IMPL(PAIRM)) u_txe (
    .clk_i, .rst_ni, .set_i({tlen, tcs}),
    .clr_we_i(reg_wr_i && hit(a, A_TXE)), .clr_data_i(reg_wdata_i), .stat_o(txe_q));

  qic_rw_reg #(.W(32), .IMPL(PAIRM)) u_done_en (
    .clk_i, .rst_ni, .we_i(reg_wr_i && hit(a, A_DONE_EN)), .wdata_i(reg_wdata_i), .q_o(done_en));
  qic_rw_reg #(.W(32), .IMPL(PAIRM)) u_rxe_en (
    .clk_i, .rst_ni, .we_i(reg_wr_i && hit(a, A_RXE_EN)), .wdata_i(reg_wdata_i), .q_o(rxe_en));
  qic_rw_reg #(.W(HALF_W), .IMPL(EPM)) u_zlp_en (
    .clk_i, .rst_ni, .we_i(reg_wr_i && hit(a, A_ZLP_EN)),
    .wdata_i(reg_wdata_i[HALF_W-1:0]), .q_o(zlp_en));
  qic_rw_reg #(.W(32), .IMPL(PAIRM)) u_txe_en (
    .clk_i, .rst_ni, .we_i(reg_wr_i && hit(a, A_TXE_EN)), .wdata_i(reg_wdata_i), .q_o(txe_en));
  qic_rw_reg #(.W(NUM_GRP), .IMPL(SUMM)) u_sum_en (
    .clk_i, .rst_ni, .we_i(reg_wr_i && hit(a, A_SUM_EN)),
    .wdata_i(reg_wdata_i[NUM_GRP-1:0]), .q_o(sum_en));

  // group views, indexed by grp_e
  logic [HALF_W-1:0] g_stat [NUM_GRP];
  logic [HALF_W-1:0] g_en [NUM_GRP];
  always_comb begin
    g_stat[GRP_RX_CS] = rxe_q[15:0];  g_en[GRP_RX_CS] = rxe_en[15:0];
    g_stat[GRP_RX_LEN] = rxe_q[31:16]; g_en[GRP_RX_LEN] = rxe_en[31:16];
    g_stat[GRP_RX_ZLP] = zlp_q;        g_en[GRP_RX_ZLP] = zlp_en;
    g_stat[GRP_TX_CS] = txe_q[15:0];  g_en[GRP_TX_CS] = txe_en[15:0];
    g_stat[GRP_TX_LEN] = txe_q[31:16]; g_en[GRP_TX_LEN] = txe_en[31:16];
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_sum
    assign sum[g] = |(g_stat[g] & g_en[g]);
  end

  logic pend;
  assign pend = (|(done_q & done_en)) | (|(sum & sum_en));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else irq_o <= pend;
  end

  always_comb begin
    reg_rdata_o = '0;
    case (a)
      ADDR_W'(A_DONE):    reg_rdata_o = done_q;
      ADDR_W'(A_DONE_EN): reg_rdata_o = done_en;
      ADDR_W'(A_SUM):     reg_rdata_o[NUM_GRP-1:0] = sum;
      ADDR_W'(A_SUM_EN):  reg_rdata_o[NUM_GRP-1:0] = sum_en;
      ADDR_W'(A_RXE):     reg_rdata_o = rxe_q;
      ADDR_W'(A_RXE_EN):  reg_rdata_o = rxe_en;
      ADDR_W'(A_ZLP):     reg_rdata_o[HALF_W-1:0] = zlp_q;
      ADDR_W'(A_ZLP_EN):  reg_rdata_o[HALF_W-1:0] = zlp_en;
      ADDR_W'(A_TXE):     reg_rdata_o = txe_q;
      ADDR_W'(A_TXE_EN):  reg_rdata_o = txe_en;
      default:            reg_rdata_o = '0;
    endcase
  end

  // R9
  irq_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(done_q & done_en)) || (|(sum & sum_en))) |=> irq_o);

  // R9
  irq_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|(done_q & done_en)) || (|(sum & sum_en))) |=> !irq_o);

  // R3
  ep0_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q[0] == 1'b0) && (done_q[16] == 1'b0) && (txe_q[0] == 1'b0) && (rxe_q[16] == 1'b0));
endmodule

// File: tb/sim_queue_irq_ctrl.sv
module sim_queue_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] tx_done, rx_done, rcs, rlen, rzlp, tcs, tlen;
  logic wr;
  logic [3:0] addr;
  logic [31:0] wdata, rdata;
  logic irq;

  queue_irq_ctrl #(.NUM_EP(16), .ADDR_W(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_done_i(tx_done), .rx_done_i(rx_done),
    .rx_cs_err_i(rcs), .rx_len_err_i(rlen), .rx_zlp_err_i(rzlp),
    .tx_cs_err_i(tcs), .tx_len_err_i(tlen),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq));

  int checks = 0;
  int errors = 0;

  // {tx events, rx events, clear word, expected completion word}
  localparam int NV = 8;
  localparam logic [95:0] VEC [NV] = '{
    {16'h0003, 16'h0000, 32'h0000_0000, 32'h0000_0002},
    {16'h0000, 16'h8001, 32'h0000_0000, 32'h8000_0002},
    {16'h0010, 16'h0000, 32'h0000_0002, 32'h8000_0010},
    {16'h0010, 16'h0000, 32'h0000_0010, 32'h8000_0010},
    {16'h0000, 16'h0000, 32'hFFFF_FFFF, 32'h0000_0000},
    {16'hFFFF, 16'hFFFF, 32'h0000_0000, 32'hFFFE_FFFE},
    {16'h0000, 16'h0000, 32'h00FF_00FF, 32'hFF00_FF00},
    {16'h0000, 16'h0000, 32'hFF00_FF00, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    wr = 1'b0; wdata = '0;
    tx_done = '0; rx_done = '0; rcs = '0; rlen = '0; rzlp = '0; tcs = '0; tlen = '0;
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic rreg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(); addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rreg(4'(a), v);
      chk("R1 reset reg", v, 32'h0);
    end
    chk("R1 reset irq", {31'h0, irq}, 32'h0);

    // R2 R3 R4 R5 table, completion enable left at 0
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      tx_done = VEC[i][95:80]; rx_done = VEC[i][79:64];
      wr = |VEC[i][63:32]; addr = 4'd0; wdata = VEC[i][63:32];
      @(negedge clk);
      idle();
      #1 chk("R2/R3/R4/R5 done word", rdata, VEC[i][31:0]);
      chk("R10 irq stays low while disabled", {31'h0, irq}, 32'h0);
    end

    // R8 enable readback and R3 unimplemented bits
    wreg(4'd1, 32'hFFFF_FFFF); rreg(4'd1, v); chk("R8 done enable", v, 32'hFFFE_FFFE);
    wreg(4'd9, 32'hFFFF_FFFF); rreg(4'd9, v); chk("R8 tx err enable", v, 32'hFFFE_FFFE);
    wreg(4'd7, 32'hFFFF_FFFF); rreg(4'd7, v); chk("R8 zlp enable", v, 32'h0000_FFFE);
    wreg(4'd1, 32'h0000_0004); rreg(4'd1, v); chk("R8 done enable narrow", v, 32'h0000_0004);

    // R9 irq timing
    @(negedge clk); tx_done = 16'h0004;
    @(negedge clk); idle();
    chk("R9 irq not yet", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R9 irq raised", {31'h0, irq}, 32'h1);
    @(negedge clk); wr = 1'b1; addr = 4'd0; wdata = 32'h0000_0004;
    @(negedge clk); idle();
    chk("R9 irq held one cycle", {31'h0, irq}, 32'h1);
    @(negedge clk);
    chk("R9 irq dropped", {31'h0, irq}, 32'h0);

    // R6 R7 R10 error path
    wreg(4'd5, 32'h0002_0000);
    wreg(4'd7, 32'h0000_8000);
    wreg(4'd9, 32'h0000_0000);
    @(negedge clk);
    rlen = 16'h0002; rcs = 16'h0008; rzlp = 16'h8001; tcs = 16'h0020; tlen = 16'h0020;
    @(negedge clk); idle();
    rreg(4'd4, v); chk("R6 rx err word", v, 32'h0002_0008);
    rreg(4'd6, v); chk("R6 zlp word", v, 32'h0000_8000);
    rreg(4'd8, v); chk("R6 tx err word", v, 32'h0020_0020);
    rreg(4'd2, v); chk("R7 summary partial enables", v, 32'h0000_0006);
    chk("R10 irq low without summary enable", {31'h0, irq}, 32'h0);
    wreg(4'd9, 32'h0020_0020);
    rreg(4'd2, v); chk("R7 summary all groups", v, 32'h0000_001E);
    wreg(4'd2, 32'h0000_001F);
    rreg(4'd2, v); chk("R7 summary write ignored", v, 32'h0000_001E);
    wreg(4'd3, 32'h0000_0002);
    @(negedge clk);
    chk("R9 irq from summary", {31'h0, irq}, 32'h1);
    wreg(4'd4, 32'h0002_0000);
    rreg(4'd4, v); chk("R4 rx err partial clear", v, 32'h0000_0008);
    rreg(4'd2, v); chk("R7 summary after clear", v, 32'h0000_001C);
    @(negedge clk);
    chk("R9 irq drops after group clear", {31'h0, irq}, 32'h0);
    wreg(4'd3, 32'h0000_0010);
    @(negedge clk);
    chk("R9 irq from tx len group", {31'h0, irq}, 32'h1);
    wreg(4'd9, 32'h0000_0000);
    rreg(4'd2, v); chk("R7 summary off when disabled", v, 32'h0000_0004);
    rreg(4'd8, v); chk("R10 status kept when disabled", v, 32'h0020_0020);
    @(negedge clk);
    chk("R9 irq low after disable", {31'h0, irq}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule